// File: doc/BRIEF.md
# Downstream Port Reset Flush Controller

This block sits between the primary (upstream) side of a downstream port and its link. In normal operation it passes outbound requests toward the link and inbound traffic toward the primary side. It also records which non-posted requests are still waiting for a completion. A single software-writable control bit starts a hot reset. While the bit is 1, the block asserts a hot-reset output toward the link training logic and empties the transaction layer. Each transaction class is handled in its own way:

- Outbound posted requests are thrown away.
- Each outbound non-posted request is answered on the primary side with an Unsupported Request completion.
- All inbound traffic (completions and posted writes) is accepted and discarded as it arrives.

The control bit belongs to the bridge configuration and is never cleared by the reset it triggers. The outstanding-request record is wiped when software clears the bit. As a result, completions that arrive late after the reset are never forwarded.

Every data interface uses valid/ready. A transfer happens on a clock edge where both valid and ready are high. A source must keep valid and its payload stable until the transfer happens. In normal operation, back-pressure passes straight through the block.

During the flush, the block never applies back-pressure to any input, with one exception: outbound non-posted requests are accepted only while the Unsupported Request completion queue has room. That queue drains through its own valid/ready stream.

Top module: `port_reset_flush`

## Requirements
- R1: After power-on reset, the control bit reads 0, `hot_reset` is 0, no completion for an outstanding request is forwarded, and `ur_valid` is 0.
- R2: A register write with data 1 sets the control bit and raises `hot_reset` from the next cycle. `hot_reset` stays high while the bit is 1, and the bit is not cleared by the flush. A write with data 0 drops both from the next cycle.
- R3: With the bit at 0, outbound requests pass through. `ob_out_valid` equals `ob_in_valid`, `ob_in_ready` equals `ob_out_ready`, and the payload is unchanged.
- R4: With the bit at 1, outbound posted requests (`ob_in_posted`=1) are accepted with `ob_in_ready`=1 and never appear at `ob_out_valid`.
- R5: With the bit at 1, each accepted outbound non-posted request produces one completion on the UR stream. That completion carries the request's requester ID and tag, with status code 3'b001. `ob_in_ready` for non-posted requests equals "UR queue not full".
- R6: UR completions leave in the order their requests were accepted. While `ur_valid`=1 and `ur_ready`=0, the UR outputs hold steady.
- R7: With the bit at 0, an inbound completion (`ib_in_is_cpl`=1) is forwarded only if its tag has an outstanding non-posted request. Forwarding it retires that tag. A completion with no outstanding tag is accepted and dropped.
- R8: With the bit at 1, every inbound transfer, whether completion or posted write, sees `ib_in_ready`=1 and is never forwarded.
- R9: When software clears the bit, all outstanding tags are forgotten, so a completion for a request sent before the reset is dropped afterwards.
- R10: With the bit at 0, inbound posted writes (`ib_in_is_cpl`=0) pass through with their valid/ready and payload unchanged.
- R11: A change of the control bit affects how traffic is handled only from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cfg_wr_en | input | 1 | Register write strobe for the control bit |
| cfg_wr_data | input | 1 | Value written to the control bit |
| cfg_bit | output | 1 | Current value of the control bit |
| hot_reset | output | 1 | Hot-reset request toward link training |
| ob_in_valid | input | 1 | Outbound request valid (from primary side) |
| ob_in_ready | output | 1 | Outbound request ready |
| ob_in_posted | input | 1 | 1 = posted, 0 = non-posted |
| ob_in_reqid | input | REQID_W | Requester ID |
| ob_in_tag | input | TAG_W | Request tag |
| ob_in_data | input | DATA_W | Request payload |
| ob_out_valid | output | 1 | Outbound request valid toward link |
| ob_out_ready | input | 1 | Link ready for outbound request |
| ob_out_posted | output | 1 | Forwarded posted flag |
| ob_out_reqid | output | REQID_W | Forwarded requester ID |
| ob_out_tag | output | TAG_W | Forwarded tag |
| ob_out_data | output | DATA_W | Forwarded payload |
| ib_in_valid | input | 1 | Inbound transfer valid (from link) |
| ib_in_ready | output | 1 | Inbound transfer ready |
| ib_in_is_cpl | input | 1 | 1 = completion, 0 = posted write |
| ib_in_tag | input | TAG_W | Completion tag |
| ib_in_data | input | DATA_W | Inbound payload |
| ib_out_valid | output | 1 | Inbound transfer valid toward primary |
| ib_out_ready | input | 1 | Primary ready for inbound transfer |
| ib_out_is_cpl | output | 1 | Forwarded completion flag |
| ib_out_tag | output | TAG_W | Forwarded tag |
| ib_out_data | output | DATA_W | Forwarded payload |
| ur_valid | output | 1 | UR completion valid |
| ur_ready | input | 1 | Primary ready for UR completion |
| ur_reqid | output | REQID_W | Requester ID echoed |
| ur_tag | output | TAG_W | Tag echoed |
| ur_status | output | 3 | Completion status, 3'b001 = Unsupported Request |

## Verification
The traffic is random and mixes posted and non-posted outbound requests with inbound completions and posted writes. Tags are drawn from a small pool, so inbound completions often hit an outstanding tag and often miss one; this separates the forwarding rule from plain pass-through. `ur_ready` is held low for stretches during the flush. This fills the UR queue and shows both the queue-full back-pressure and whether the completions come out in order. A directed sequence sends a non-posted request, runs a reset, and then returns a completion for that request. That completion must be dropped, which distinguishes a tracker that is wiped at the end of the reset from one that keeps its tags.

// File: rtl/pflush_pkg.sv
package pflush_pkg;
  localparam logic [2:0] CPL_STATUS_UR = 3'b001;
endpackage

// File: rtl/pflush_ctl_bit.sv
module pflush_ctl_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_data,
  output logic bit_q,
  output logic flush_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bit_q <= 1'b0;
    else if (wr_en) bit_q <= wr_data;
  end

  // Falling edge of the control bit: tracker wipe happens on this edge.
  assign flush_end = bit_q & wr_en & ~wr_data;
endmodule

// File: rtl/pflush_tracker.sv
module pflush_tracker #(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  input  logic             clr_all,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit
);
  localparam int N = 1 << TAG_W;
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  pend_q[i] <= 1'b0;
      else if (clr_all)                            pend_q[i] <= 1'b0;
      else if (set_en && set_tag == TAG_W'(i))     pend_q[i] <= 1'b1;
      else if (clr_en && clr_tag == TAG_W'(i))     pend_q[i] <= 1'b0;
    end
  end

  assign hit = pend_q[look_tag];
endmodule

// File: rtl/pflush_ur_fifo.sv
module pflush_ur_fifo #(
  parameter int W     = 21,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         pop_valid,
  input  logic         pop_ready,
  output logic [W-1:0] pop_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full      = (cnt_q == CW'(DEPTH));
  assign pop_valid = (cnt_q != '0);
  assign pop_data  = mem[rp_q];
  assign do_push   = push && !full;
  assign do_pop    = pop_valid && pop_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/port_reset_flush.sv
module port_reset_flush #(
  parameter int REQID_W  = 16,
  parameter int TAG_W    = 5,
  parameter int DATA_W   = 32,
  parameter int UR_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic               cfg_wr_data,
  output logic               cfg_bit,
  output logic               hot_reset,
  input  logic               ob_in_valid,
  output logic               ob_in_ready,
  input  logic               ob_in_posted,
  input  logic [REQID_W-1:0] ob_in_reqid,
  input  logic [TAG_W-1:0]   ob_in_tag,
  input  logic [DATA_W-1:0]  ob_in_data,
  output logic               ob_out_valid,
  input  logic               ob_out_ready,
  output logic               ob_out_posted,
  output logic [REQID_W-1:0] ob_out_reqid,
  output logic [TAG_W-1:0]   ob_out_tag,
  output logic [DATA_W-1:0]  ob_out_data,
  input  logic               ib_in_valid,
  output logic               ib_in_ready,
  input  logic               ib_in_is_cpl,
  input  logic [TAG_W-1:0]   ib_in_tag,
  input  logic [DATA_W-1:0]  ib_in_data,
  output logic               ib_out_valid,
  input  logic               ib_out_ready,
  output logic               ib_out_is_cpl,
  output logic [TAG_W-1:0]   ib_out_tag,
  output logic [DATA_W-1:0]  ib_out_data,
  output logic               ur_valid,
  input  logic               ur_ready,
  output logic [REQID_W-1:0] ur_reqid,
  output logic [TAG_W-1:0]   ur_tag,
  output logic [2:0]         ur_status
);
  import pflush_pkg::*;

  localparam int UR_W = REQID_W + TAG_W;

  logic flushing, flush_end;
  logic ur_full, ur_push;
  logic np_fwd, cpl_hit, cpl_fwd, cpl_stray;
  logic [UR_W-1:0] ur_word;

  pflush_ctl_bit u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .bit_q(flushing), .flush_end(flush_end)
  );

  assign cfg_bit   = flushing;
  assign hot_reset = flushing;

  // Outbound side
  assign ob_out_valid  = ob_in_valid && !flushing;
  assign ob_out_posted = ob_in_posted;
  assign ob_out_reqid  = ob_in_reqid;
  assign ob_out_tag    = ob_in_tag;
  assign ob_out_data   = ob_in_data;

  always_comb begin
    if (!flushing)         ob_in_ready = ob_out_ready;
    else if (ob_in_posted) ob_in_ready = 1'b1;
    else                   ob_in_ready = !ur_full;
  end

  assign np_fwd  = !flushing && ob_in_valid && ob_out_ready && !ob_in_posted;
  assign ur_push = flushing && ob_in_valid && !ob_in_posted && !ur_full;

  // Inbound side
  assign cpl_stray = ib_in_is_cpl && !cpl_hit;
  assign ib_out_valid  = ib_in_valid && !flushing && !cpl_stray;
  assign ib_in_ready   = flushing || cpl_stray || ib_out_ready;
  assign ib_out_is_cpl = ib_in_is_cpl;
  assign ib_out_tag    = ib_in_tag;
  assign ib_out_data   = ib_in_data;
  assign cpl_fwd = ib_out_valid && ib_out_ready && ib_in_is_cpl;

  pflush_tracker #(.TAG_W(TAG_W)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .set_en(np_fwd), .set_tag(ob_in_tag),
    .clr_en(cpl_fwd), .clr_tag(ib_in_tag),
    .clr_all(flush_end),
    .look_tag(ib_in_tag), .hit(cpl_hit)
  );

  pflush_ur_fifo #(.W(UR_W), .DEPTH(UR_DEPTH)) u_urq (
    .clk(clk), .rst_n(rst_n),
    .push(ur_push), .push_data({ob_in_reqid, ob_in_tag}),
    .full(ur_full),
    .pop_valid(ur_valid), .pop_ready(ur_ready), .pop_data(ur_word)
  );

  assign ur_reqid  = ur_word[UR_W-1 -: REQID_W];
  assign ur_tag    = ur_word[TAG_W-1:0];
  assign ur_status = CPL_STATUS_UR;
endmodule

// File: rtl/port_reset_flush_chk.sv
module port_reset_flush_chk #(
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic             cfg_wr_data,
  input logic             hot_reset,
  input logic             ob_in_valid,
  input logic             ob_in_ready,
  input logic             ob_in_posted,
  input logic             ob_out_valid,
  input logic             ib_in_ready,
  input logic             ib_out_valid,
  input logic             ur_valid,
  input logic             ur_ready,
  input logic [TAG_W-1:0] ur_tag
);
  p_set_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && cfg_wr_data |=> hot_reset);
  p_clear_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && !cfg_wr_data |=> !hot_reset);
  p_ob_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hot_reset |-> !ob_out_valid);
  p_np_answers_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hot_reset && ob_in_valid && !ob_in_posted && ob_in_ready |=> ur_valid);
  p_ur_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ur_valid && !ur_ready |=> ur_valid && $stable(ur_tag));
  p_ib_sink_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hot_reset |-> ib_in_ready && !ib_out_valid);
endmodule

bind port_reset_flush port_reset_flush_chk #(.TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .hot_reset(hot_reset), .ob_in_valid(ob_in_valid), .ob_in_ready(ob_in_ready),
  .ob_in_posted(ob_in_posted), .ob_out_valid(ob_out_valid),
  .ib_in_ready(ib_in_ready), .ib_out_valid(ib_out_valid),
  .ur_valid(ur_valid), .ur_ready(ur_ready), .ur_tag(ur_tag)
);

// File: tb/port_reset_flush_test.sv
module port_reset_flush_test;
  localparam int RW = 16, TW = 5, DW = 32, DEP = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0, cfg_wr_data = 0, cfg_bit, hot_reset;
  logic ob_in_valid = 0, ob_in_ready, ob_in_posted = 0;
  logic [RW-1:0] ob_in_reqid = 0; logic [TW-1:0] ob_in_tag = 0; logic [DW-1:0] ob_in_data = 0;
  logic ob_out_valid, ob_out_ready = 0, ob_out_posted;
  logic [RW-1:0] ob_out_reqid; logic [TW-1:0] ob_out_tag; logic [DW-1:0] ob_out_data;
  logic ib_in_valid = 0, ib_in_ready, ib_in_is_cpl = 0;
  logic [TW-1:0] ib_in_tag = 0; logic [DW-1:0] ib_in_data = 0;
  logic ib_out_valid, ib_out_ready = 0, ib_out_is_cpl;
  logic [TW-1:0] ib_out_tag; logic [DW-1:0] ib_out_data;
  logic ur_valid, ur_ready = 0; logic [RW-1:0] ur_reqid; logic [TW-1:0] ur_tag; logic [2:0] ur_status;

  always #10 clk = ~clk;

  port_reset_flush uut (.*);

  int tests = 0, fails = 0;
  bit m_bit = 0;
  bit m_pend [32];
  logic [RW+TW-1:0] m_urq [$];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare all outputs against the model, then advance the model one clock.
  task automatic step();
    bit e_obv, e_obr, e_ibv, e_ibr, stray, nb;
    #2;
    e_obv = ob_in_valid && !m_bit;
    e_obr = !m_bit ? ob_out_ready : (ob_in_posted ? 1'b1 : (m_urq.size() < DEP));
    stray = ib_in_is_cpl && !m_pend[ib_in_tag];
    e_ibv = ib_in_valid && !m_bit && !stray;
    e_ibr = m_bit || stray || ib_out_ready;
    chk(hot_reset == m_bit && cfg_bit == m_bit, "R2 bit/hot_reset", {cfg_bit, hot_reset}, {m_bit, m_bit});
    chk(ob_out_valid == e_obv, m_bit ? "R4 ob_out_valid" : "R3 ob_out_valid", ob_out_valid, e_obv);
    chk(ob_in_ready == e_obr, m_bit ? "R5 ob_in_ready" : "R3 ob_in_ready", ob_in_ready, e_obr);
    if (e_obv) chk({ob_out_posted, ob_out_reqid, ob_out_tag, ob_out_data} ==
                   {ob_in_posted, ob_in_reqid, ob_in_tag, ob_in_data}, "R3 payload", ob_out_tag, ob_in_tag);
    chk(ib_out_valid == e_ibv, m_bit ? "R8 ib_out_valid" : (ib_in_is_cpl ? "R7 ib_out_valid" : "R10 ib_out_valid"), ib_out_valid, e_ibv);
    chk(ib_in_ready == e_ibr, m_bit ? "R8 ib_in_ready" : "R7 ib_in_ready", ib_in_ready, e_ibr);
    if (e_ibv) chk({ib_out_is_cpl, ib_out_tag, ib_out_data} == {ib_in_is_cpl, ib_in_tag, ib_in_data},
                   "R10 ib payload", ib_out_data, ib_in_data);
    chk(ur_valid == (m_urq.size() > 0), "R5 ur_valid", ur_valid, m_urq.size() > 0);
    if (m_urq.size() > 0) begin
      chk({ur_reqid, ur_tag} == m_urq[0], "R6 ur order", {ur_reqid, ur_tag}, m_urq[0]);
      chk(ur_status == 3'b001, "R5 ur_status", ur_status, 3'b001);
    end
    // next state
    nb = cfg_wr_en ? cfg_wr_data : m_bit;
    if (ur_ready && m_urq.size() > 0) void'(m_urq.pop_front());
    if (m_bit && ob_in_valid && !ob_in_posted && e_obr) m_urq.push_back({ob_in_reqid, ob_in_tag});
    if (m_bit && !nb) begin
      foreach (m_pend[i]) m_pend[i] = 0;
    end else begin
      if (e_ibv && ib_out_ready && ib_in_is_cpl) m_pend[ib_in_tag] = 0;
      if (e_obv && ob_out_ready && !ob_in_posted) m_pend[ob_in_tag] = 1;
    end
    m_bit = nb;
    @(posedge clk); #1;
  endtask

  task automatic rand_in(input int urp);
    ob_in_valid  = ($urandom % 3) != 0;
    ob_in_posted = $urandom % 2;
    ob_in_reqid  = RW'($urandom);
    ob_in_tag    = TW'($urandom % 6);
    ob_in_data   = $urandom;
    ob_out_ready = ($urandom % 4) != 0;
    ib_in_valid  = ($urandom % 3) != 0;
    ib_in_is_cpl = ($urandom % 3) != 0;
    ib_in_tag    = TW'($urandom % 6);
    ib_in_data   = $urandom;
    ib_out_ready = ($urandom % 4) != 0;
    ur_ready     = ($urandom % 100) < urp;
    cfg_wr_en    = 0;
  endtask

  task automatic idle();
    ob_in_valid = 0; ib_in_valid = 0; cfg_wr_en = 0; ur_ready = 1;
  endtask

  task automatic wr_bit(input bit v);
    idle(); cfg_wr_en = 1; cfg_wr_data = v; step(); cfg_wr_en = 0;
  endtask

  initial begin
    foreach (m_pend[i]) m_pend[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(cfg_bit == 0 && hot_reset == 0, "R1 reset bit", {cfg_bit, hot_reset}, 0);
    chk(ur_valid == 0, "R1 ur_valid", ur_valid, 0);
    rst_n = 1;
    idle(); ib_in_valid = 1; ib_in_is_cpl = 1; ib_in_tag = 3; ib_out_ready = 1;
    #2; chk(ib_out_valid == 0, "R1 no outstanding cpl", ib_out_valid, 0);
    @(posedge clk); #1;
    for (int r = 0; r < 6; r++) begin
      for (int c = 0; c < 150; c++) begin rand_in(100); step(); end
      wr_bit(1);
      // R11: the write cycle itself was handled in normal mode; now in flush
      chk(hot_reset == 1, "R11 hot_reset after write", hot_reset, 1);
      for (int c = 0; c < 150; c++) begin rand_in((c / 30) % 2 ? 20 : 90); step(); end
      chk(cfg_bit == 1, "R2 bit retained", cfg_bit, 1);
      wr_bit(0);
      chk(hot_reset == 0, "R2 hot_reset dropped", hot_reset, 0);
    end
    // R9 directed: outstanding tag 9 forgotten after reset
    idle(); ob_in_valid = 1; ob_in_posted = 0; ob_in_tag = 9; ob_out_ready = 1; step();
    idle(); wr_bit(1); wr_bit(0);
    idle(); ib_in_valid = 1; ib_in_is_cpl = 1; ib_in_tag = 9; ib_out_ready = 1;
    #2; chk(ib_out_valid == 0, "R9 late cpl dropped", ib_out_valid, 0);
    step();
    idle();
    repeat (8) step();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule